// File: doc/BRIEF.md
# Periodic Internal Command Scheduler with Collision Skip

This block decides, once per multiplexing frame, whether an internal parameter-update command should be placed on a command bus that it shares with data-retrieval traffic. The command carries either a ramp value or an arbitrary-waveform index. Commands fall due every `step_period_i` frames. The schedule is realigned at each acquisition start and delayed by `step_phase_i` frames. A decision is only ever taken on the frame-boundary pulse.

When a due command would collide with a data-retrieval request, with external bus activity, or with the block's own previous command still occupying the bus, that command is dropped. It is not postponed. The ramp or index still advances on every due frame, so the next command that does go out carries the value it would have had anyway. A header register reports the value of the last command actually issued. Values the schedule produced but dropped never reach it.

The block's own bus occupancy is modelled as a fixed busy window. That window is a fixed issue delay plus the serialised word time. The serialiser itself sits outside the block.

Top module: `int_cmd_sched`

## Requirements
- R1: `cmd_issue_o` is a one-cycle pulse. It can only rise in the clock cycle after a cycle in which `frame_tick_i` was sampled high.
- R2: While running, a command falls due on every `step_period_i`-th frame tick. A period of 0 behaves as a period of 1.
- R3: `acq_start_i` arms the scheduler and realigns the schedule. Counting ticks from 0 after the start, the first due tick is tick number `step_phase_i`. A tick in the same cycle as `acq_start_i` is not counted.
- R4: A due tick on which `data_req_i` or `bus_busy_i` is high issues no command (a skip).
- R5: In ramp mode (`mode_i` = 2'd2) the scheduled value starts at `ramp_start_i` and advances on every due tick, whether issued or skipped. Each advance adds `ramp_step_i`. When the sum would exceed `ramp_max_i`, the value returns to `ramp_start_i`.
- R6: In waveform mode (`mode_i` = 2'd3) the scheduled value is an index. It starts at 0, advances by 1 on every due tick, and returns to 0 after `ramp_max_i`.
- R7: In modes 2'd0 and 2'd1 no command issues, and the schedule count and value are frozen.
- R8: `hdr_value_o` and `cmd_value_o` change only together with an issued command, and then take the issued value. A skip leaves them unchanged.
- R9: After an issue, due ticks are skipped for the following `ISSUE_DLY + WORD_CYCLES` clock cycles (25 by default).
- R10: When data requests recur at a multiple of the step period with no phase offset, every due command is skipped.
- R11: After reset all outputs are 0, and no command issues until `acq_start_i` has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_tick_i | input | 1 | One-cycle pulse at each frame boundary |
| acq_start_i | input | 1 | One-cycle pulse at acquisition start |
| data_req_i | input | 1 | A data-retrieval command uses this frame boundary |
| bus_busy_i | input | 1 | Command bus occupied by other traffic |
| mode_i | input | 2 | 2'd2 ramp, 2'd3 waveform index, other values off |
| step_period_i | input | PER_W | Frames between due commands |
| step_phase_i | input | PER_W | Frames from acquisition start to first due command |
| ramp_start_i | input | VAL_W | Ramp start value |
| ramp_step_i | input | VAL_W | Ramp increment |
| ramp_max_i | input | VAL_W | Ramp / index upper limit |
| cmd_issue_o | output | 1 | Internal command issued (one-cycle pulse) |
| cmd_value_o | output | VAL_W | Value carried by the last issued command |
| hdr_value_o | output | VAL_W | Header value: last issued value |

## Verification
The scheduler is driven with frame sequences that vary the step period, the phase, the data-request rate, isolated external busy frames and the frame spacing. A reference model compares all three outputs on every clock.

Phase offsets separate a schedule that realigns at start from one that free-runs. Data rates equal to the period, and half of it, separate "skip" from "postpone". A data rate equal to the period must give zero issues, while the same rate with phase 1 must give a full set.

Short frame spacing exercises the self-busy window. Ramp and index runs past the limit, including a skipped command right after a wrap, show that values advance on skips and that the header reports only issued values.

// File: rtl/ics_pkg.sv
// Package: shared mode encoding for the internal command scheduler.
// Assumes: mode field is two bits; the upper bit set means "commands active".
package ics_pkg;
    typedef enum logic [1:0] {
        MODE_OFF_A = 2'd0,
        MODE_OFF_B = 2'd1,
        MODE_RAMP  = 2'd2,
        MODE_WAVE  = 2'd3
    } sched_mode_e;

    // True when the mode produces internal commands
    function automatic logic mode_active(input logic [1:0] m);
        return m[1];
    endfunction
endpackage

// File: rtl/ics_frame_sched.sv
// Module: frame countdown deciding which frame ticks carry a due command.
// Assumes: step_i is already qualified (armed, active mode, no restart).
//          A period of 0 is treated as 1. Restart loads the phase offset.
module ics_frame_sched #(
    parameter int PER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic             step_i,
    input  logic [PER_W-1:0] period_i,
    input  logic [PER_W-1:0] phase_i,
    output logic             due_o
);
    logic [PER_W-1:0] cnt_q;
    logic [PER_W-1:0] reload;

    // Reload value: frames to wait after a due tick
    always_comb begin
        reload = (period_i == '0) ? '0 : period_i - PER_W'(1);
    end

    assign due_o = step_i && (cnt_q == '0);

    // Countdown: restart aligns to phase, each qualified tick counts down
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart_i) begin
            cnt_q <= phase_i;
        end else if (step_i) begin
            cnt_q <= (cnt_q == '0) ? reload : cnt_q - PER_W'(1);
        end
    end

    // R3: a restart always lands on the phase offset
    assert_phase_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> cnt_q == $past(phase_i))
        else $error("phase load failed");
endmodule

// File: rtl/ics_value_gen.sv
// Module: ramp value / waveform index generator.
// Assumes: advance_i pulses once per due tick (issued or skipped).
//          Ramp mode: start, add stride, wrap to start when above limit.
//          Waveform mode: start 0, stride 1, same limit.
module ics_value_gen #(
    parameter int VAL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic             advance_i,
    input  logic [1:0]       mode_i,
    input  logic [VAL_W-1:0] start_i,
    input  logic [VAL_W-1:0] stride_i,
    input  logic [VAL_W-1:0] limit_i,
    output logic [VAL_W-1:0] val_o
);
    import ics_pkg::*;

    logic [VAL_W-1:0] base;
    logic [VAL_W-1:0] inc;
    logic [VAL_W:0]   sum;
    logic [VAL_W-1:0] nxt;

    // Per-mode origin and increment, then wrap at the limit
    always_comb begin
        base = (mode_i == MODE_WAVE) ? '0 : start_i;
        inc  = (mode_i == MODE_WAVE) ? VAL_W'(1) : stride_i;
        sum  = {1'b0, val_o} + {1'b0, inc};
        nxt  = (sum > {1'b0, limit_i}) ? base : sum[VAL_W-1:0];
    end

    // Value register: reload on restart, step on every due tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_o <= '0;
        end else if (restart_i) begin
            val_o <= base;
        end else if (advance_i) begin
            val_o <= nxt;
        end
    end

    // R5: a ramp advance either climbs or returns to the start value
    assert_ramp_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (advance_i && !restart_i && mode_i == MODE_RAMP && stride_i != '0)
        |=> (val_o == $past(start_i) || val_o > $past(val_o)))
        else $error("ramp advance out of order");

    // R6: the waveform index steps by one or returns to zero
    assert_index_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (advance_i && !restart_i && mode_i == MODE_WAVE)
        |=> (val_o == '0 || val_o == $past(val_o) + VAL_W'(1)))
        else $error("index advance out of order");
endmodule

// File: rtl/ics_issue_ctl.sv
// Module: issue decision, self-busy window and header register.
// Assumes: due_i is a single-cycle strobe; collide_i reflects other bus
//          traffic in the same cycle. Issue blocks for BUSY_CYC cycles.
module ics_issue_ctl #(
    parameter int VAL_W    = 16,
    parameter int BUSY_CYC = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             due_i,
    input  logic             collide_i,
    input  logic [VAL_W-1:0] val_i,
    output logic             issue_o,
    output logic [VAL_W-1:0] cmd_val_o,
    output logic [VAL_W-1:0] hdr_o
);
    localparam int CW = $clog2(BUSY_CYC + 1);

    logic [CW-1:0] busy_q;
    logic          go;

    assign go = due_i && !collide_i && (busy_q == '0);

    // Issue pulse, payload and header capture on an actual issue
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issue_o   <= 1'b0;
            cmd_val_o <= '0;
            hdr_o     <= '0;
        end else begin
            issue_o <= go;
            if (go) begin
                cmd_val_o <= val_i;
                hdr_o     <= val_i;
            end
        end
    end

    // Busy window: load on issue, count down to idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= '0;
        end else if (go) begin
            busy_q <= CW'(BUSY_CYC);
        end else if (busy_q != '0) begin
            busy_q <= busy_q - CW'(1);
        end
    end

    // R9: no issue may follow a cycle in which the bus is still ours
    assert_busy_guard_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q != '0) |=> !issue_o)
        else $error("issue during busy window");

    // R8: header holds between issues
    assert_hdr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_o |-> $stable(hdr_o))
        else $error("header moved without issue");

    // R8: header and payload agree whenever a command goes out
    assert_hdr_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        issue_o |-> hdr_o == cmd_val_o)
        else $error("header differs from payload");
endmodule

// File: rtl/int_cmd_sched.sv
// Module: top of the internal command scheduler.
// Assumes: frame_tick_i and acq_start_i are single-cycle pulses; mode and
//          parameters are stable during an acquisition. A start pulse
//          takes precedence over a tick in the same cycle.
module int_cmd_sched #(
    parameter int VAL_W       = 16,
    parameter int PER_W       = 8,
    parameter int ISSUE_DLY   = 17,
    parameter int WORD_CYCLES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_tick_i,
    input  logic             acq_start_i,
    input  logic             data_req_i,
    input  logic             bus_busy_i,
    input  logic [1:0]       mode_i,
    input  logic [PER_W-1:0] step_period_i,
    input  logic [PER_W-1:0] step_phase_i,
    input  logic [VAL_W-1:0] ramp_start_i,
    input  logic [VAL_W-1:0] ramp_step_i,
    input  logic [VAL_W-1:0] ramp_max_i,
    output logic             cmd_issue_o,
    output logic [VAL_W-1:0] cmd_value_o,
    output logic [VAL_W-1:0] hdr_value_o
);
    import ics_pkg::*;

    localparam int BUSY_CYC = ISSUE_DLY + WORD_CYCLES;

    logic             armed_q;
    logic             run_tick;
    logic             due;
    logic             collide;
    logic [VAL_W-1:0] sched_val;

    assign run_tick = frame_tick_i && armed_q && mode_active(mode_i) && !acq_start_i;
    assign collide  = data_req_i || bus_busy_i;

    // Arm flag: set by the first acquisition start after reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (acq_start_i) begin
            armed_q <= 1'b1;
        end
    end

    ics_frame_sched #(.PER_W(PER_W)) i_frame_sched (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (acq_start_i),
        .step_i    (run_tick),
        .period_i  (step_period_i),
        .phase_i   (step_phase_i),
        .due_o     (due)
    );

    ics_value_gen #(.VAL_W(VAL_W)) i_value_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (acq_start_i),
        .advance_i (due),
        .mode_i    (mode_i),
        .start_i   (ramp_start_i),
        .stride_i  (ramp_step_i),
        .limit_i   (ramp_max_i),
        .val_o     (sched_val)
    );

    ics_issue_ctl #(.VAL_W(VAL_W), .BUSY_CYC(BUSY_CYC)) i_issue_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .due_i     (due),
        .collide_i (collide),
        .val_i     (sched_val),
        .issue_o   (cmd_issue_o),
        .cmd_val_o (cmd_value_o),
        .hdr_o     (hdr_value_o)
    );

    // R1: commands only leave right after a frame tick
    assert_tick_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_issue_o |-> $past(frame_tick_i))
        else $error("issue without frame tick");

    // R1: issue is a single-cycle pulse
    assert_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_issue_o |=> !cmd_issue_o)
        else $error("issue longer than one cycle");

    // R4: no issue over data traffic or a busy bus
    assert_collide_skip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_issue_o |-> (!$past(data_req_i) && !$past(bus_busy_i)))
        else $error("issue during collision");

    // R7: only the active modes issue
    assert_mode_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_issue_o |-> $past(mode_i[1]))
        else $error("issue in inactive mode");

    // R11: nothing issues before the first acquisition start
    assert_armed_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_issue_o |-> $past(armed_q))
        else $error("issue before acquisition start");
endmodule

// File: tb/test_int_cmd_sched.sv
// Bench: behavioural reference model compared on every clock, plus
// per-scenario issue counts worked out from the requirements.
module test_int_cmd_sched;
    localparam int VW   = 16;
    localparam int PW   = 8;
    localparam int BUSY = 17 + 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_tick_i = 1'b0;
    logic          acq_start_i = 1'b0;
    logic          data_req_i = 1'b0;
    logic          bus_busy_i = 1'b0;
    logic [1:0]    mode_i = 2'd0;
    logic [PW-1:0] step_period_i = '0;
    logic [PW-1:0] step_phase_i = '0;
    logic [VW-1:0] ramp_start_i = '0;
    logic [VW-1:0] ramp_step_i = '0;
    logic [VW-1:0] ramp_max_i = '0;
    logic          cmd_issue_o;
    logic [VW-1:0] cmd_value_o;
    logic [VW-1:0] hdr_value_o;

    int checks = 0;
    int failures = 0;
    int n_issue = 0;
    int cyc = 0;
    string cur_req = "R11";

    // Reference model state
    bit m_armed = 0;
    int m_cnt = 0;
    int m_val = 0;
    int m_hdr = 0;
    int m_cmd = 0;
    bit m_issue = 0;
    int m_last = -1000;

    always #5 clk = ~clk;

    int_cmd_sched i_int_cmd_sched (
        .clk(clk), .rst_n(rst_n), .frame_tick_i(frame_tick_i),
        .acq_start_i(acq_start_i), .data_req_i(data_req_i),
        .bus_busy_i(bus_busy_i), .mode_i(mode_i),
        .step_period_i(step_period_i), .step_phase_i(step_phase_i),
        .ramp_start_i(ramp_start_i), .ramp_step_i(ramp_step_i),
        .ramp_max_i(ramp_max_i), .cmd_issue_o(cmd_issue_o),
        .cmd_value_o(cmd_value_o), .hdr_value_o(hdr_value_o)
    );

    // Reference model: behaviour of one clock edge from the requirements
    always @(posedge clk) begin
        int per;
        int nxt;
        bit blocked;
        cyc = cyc + 1;
        m_issue = 0;
        if (!rst_n) begin
            m_armed = 0; m_cnt = 0; m_val = 0; m_hdr = 0; m_cmd = 0;
            m_last = -1000;
        end else if (acq_start_i) begin
            m_armed = 1;
            m_cnt = int'(step_phase_i);
            m_val = (mode_i == 2'd2) ? int'(ramp_start_i) : 0;
        end else if (frame_tick_i && m_armed && (mode_i == 2'd2 || mode_i == 2'd3)) begin
            per = (step_period_i == 0) ? 1 : int'(step_period_i);
            if (m_cnt == 0) begin
                m_cnt = per - 1;
                blocked = data_req_i || bus_busy_i || (cyc - m_last <= BUSY);
                if (!blocked) begin
                    m_issue = 1; m_cmd = m_val; m_hdr = m_val; m_last = cyc;
                end
                if (mode_i == 2'd2) begin
                    nxt = m_val + int'(ramp_step_i);
                    m_val = (nxt > int'(ramp_max_i)) ? int'(ramp_start_i) : nxt;
                end else begin
                    nxt = m_val + 1;
                    m_val = (nxt > int'(ramp_max_i)) ? 0 : nxt;
                end
            end else begin
                m_cnt = m_cnt - 1;
            end
        end
    end

    // Per-clock comparison against the model, away from the active edge
    always @(negedge clk) begin
        checks = checks + 1;
        if (cmd_issue_o !== m_issue || int'(cmd_value_o) != m_cmd
            || int'(hdr_value_o) != m_hdr) begin
            failures = failures + 1;
            $display("FAIL %s cycle %0d: issue/cmd/hdr actual %0b/%0d/%0d expected %0b/%0d/%0d",
                     cur_req, cyc, cmd_issue_o, cmd_value_o, hdr_value_o,
                     m_issue, m_cmd, m_hdr);
        end
        if (cmd_issue_o === 1'b1) n_issue = n_issue + 1;
    end

    // Watchdog: a hung run is a failure and still prints the summary
    initial begin
        repeat (150000) @(posedge clk);
        failures = failures + 1;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic check_val(input string tag, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            failures = failures + 1;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic start_acq(input logic [1:0] md, input int per, input int ph);
        @(negedge clk);
        mode_i = md;
        step_period_i = PW'(per);
        step_phase_i = PW'(ph);
        acq_start_i = 1'b1;
        @(negedge clk);
        acq_start_i = 1'b0;
        n_issue = 0;
    endtask

    // Frames: gap cycles apart; data every drate frames; bus busy on frame bus_at
    task automatic frames(input int n, input int gap, input int drate, input int bus_at);
        for (int i = 0; i < n; i++) begin
            repeat (gap - 1) @(negedge clk);
            frame_tick_i = 1'b1;
            data_req_i = (drate > 0) && (i % drate == 0);
            bus_busy_i = (i == bus_at);
            @(negedge clk);
            frame_tick_i = 1'b0;
            data_req_i = 1'b0;
            bus_busy_i = 1'b0;
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        ramp_start_i = 16'd5; ramp_step_i = 16'd3; ramp_max_i = 16'd20;
        repeat (3) @(negedge clk);
        check_val("R11 reset hdr", int'(hdr_value_o), 0);
        check_val("R11 reset issue", int'(cmd_issue_o), 0);
        rst_n = 1'b1;
        mode_i = 2'd2; step_period_i = 8'd1;
        cur_req = "R11";
        frames(5, 40, 0, -1);
        check_val("R11 no issue before start", n_issue, 0);
        check_val("R11 hdr before start", int'(hdr_value_o), 0);

        cur_req = "R2";
        start_acq(2'd2, 3, 0);
        frames(12, 40, 0, -1);
        check_val("R2 period 3 issues", n_issue, 4);

        cur_req = "R3";
        start_acq(2'd2, 3, 2);
        frames(12, 40, 0, -1);
        check_val("R3 phase 2 issues", n_issue, 4);
        start_acq(2'd2, 3, 5);
        frames(12, 40, 0, -1);
        check_val("R3 phase 5 issues", n_issue, 3);

        cur_req = "R4";
        start_acq(2'd2, 3, 0);
        frames(12, 40, 2, -1);
        check_val("R4 data rate 2 issues", n_issue, 2);
        start_acq(2'd2, 3, 0);
        frames(12, 40, 0, 3);
        check_val("R4 bus busy frame issues", n_issue, 3);

        cur_req = "R10";
        start_acq(2'd2, 3, 0);
        frames(12, 40, 3, -1);
        check_val("R10 aligned data rate issues", n_issue, 0);
        start_acq(2'd2, 3, 1);
        frames(12, 40, 3, -1);
        check_val("R10 phase 1 data rate 3 issues", n_issue, 4);

        cur_req = "R5";
        start_acq(2'd2, 1, 0);
        frames(7, 40, 0, -1);
        check_val("R5 ramp wrap hdr", int'(hdr_value_o), 5);
        cur_req = "R8";
        frames(1, 40, 1, -1);
        check_val("R8 hdr held on skip", int'(hdr_value_o), 5);
        frames(1, 40, 0, -1);
        check_val("R5 advance across skip", int'(hdr_value_o), 11);

        cur_req = "R6";
        start_acq(2'd3, 1, 0);
        ramp_max_i = 16'd3;
        frames(10, 40, 0, -1);
        check_val("R6 index issues", n_issue, 10);
        check_val("R6 index wrap hdr", int'(hdr_value_o), 1);
        ramp_max_i = 16'd20;

        cur_req = "R7";
        start_acq(2'd0, 1, 0);
        frames(6, 40, 0, -1);
        check_val("R7 mode 0 issues", n_issue, 0);
        start_acq(2'd1, 1, 0);
        frames(6, 40, 0, -1);
        check_val("R7 mode 1 issues", n_issue, 0);

        cur_req = "R9";
        start_acq(2'd2, 1, 0);
        frames(9, 10, 0, -1);
        check_val("R9 self busy issues", n_issue, 3);

        cur_req = "R2";
        start_acq(2'd2, 0, 0);
        frames(6, 40, 0, -1);
        check_val("R2 period 0 as 1 issues", n_issue, 6);

        cur_req = "R1";
        repeat (10) @(negedge clk);
        check_val("R1 idle without ticks", n_issue, 6);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule